// File: doc/BRIEF.md
# Framed Request Byte-Stream Parser

This block sits behind a byte-wide receive path and splits an incoming stream of request bytes into frames. Each byte arrives with a one-cycle valid strobe. A frame opens with a start code. A four-byte identifier follows, then a four-byte content length, both sent most significant byte first. The declared number of content bytes comes next, and the frame is sealed by a stop code.

The parser presents the assembled identifier and length together with a one-cycle header strobe. It forwards every content byte with its own strobe and its position within the content. It reports a good or a bad seal when the stop position is reached. A command executor further down the chain can act on byte reads, byte writes or stream writes as the content flows past. A byte write carries a four-byte control address and one data byte. A stream write carries a four-byte control address followed by a run of data bytes. The parser does not decode these.

Between frames, a dedicated end-of-transmission code asks the surrounding logic to close the connection. A length of zero is legal: the stop code then follows the length field directly.

Top module: `frame_rx`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the strobes `hdr_valid`, `pay_valid`, `frame_done`, `frame_err` and `close_req` are 0, and `msg_id` and `msg_len` are 0.
- R2: Between frames, any byte other than 0xA5 (start) and 0x04 (end of transmission) produces no strobe and leaves the parser waiting for a start byte.
- R3: A 0x04 byte between frames raises `close_req` for exactly one cycle, in the cycle after that byte is accepted.
- R4: The four bytes after the start byte form `msg_id`, with the first byte received in bits 31:24 and the last in bits 7:0.
- R5: The next four bytes form `msg_len` in the same big-endian order. `hdr_valid` pulses in the cycle after the fourth length byte, with `msg_id` and `msg_len` valid in that cycle.
- R6: Each of the `msg_len` content bytes produces a one-cycle `pay_valid` in the cycle after it is accepted, with the byte on `pay_byte` and its position on `pay_index`. Positions count from 0 upwards.
- R7: When `msg_len` is 0, the byte that follows the length field is treated as the stop byte.
- R8: A 0x5A byte in the stop position pulses `frame_done` for one cycle, and the parser then waits for a new start byte.
- R9: Any other byte in the stop position pulses `frame_err` for one cycle and returns the parser to waiting. A following start byte opens a new frame.
- R10: Inside a frame, the bytes 0xA5, 0x04 and 0x5A are taken as field or content data. They raise neither `close_req` nor `frame_done`.
- R11: A cycle with `in_valid` low advances nothing and raises no strobe, whatever is on `in_byte`. At most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_byte` carries a received byte this cycle |
| in_byte | input | 8 | Received byte |
| msg_id | output | 32 | Assembled message identifier |
| msg_len | output | 32 | Assembled content length |
| hdr_valid | output | 1 | Header complete strobe |
| pay_valid | output | 1 | Content byte strobe |
| pay_byte | output | 8 | Content byte |
| pay_index | output | 32 | Position of the content byte within the content |
| frame_done | output | 1 | Good stop byte strobe |
| frame_err | output | 1 | Bad stop byte strobe |
| close_req | output | 1 | End-of-transmission strobe |

## Verification
The assertions assume that `in_byte` matters only when `in_valid` is high. They also assume that no byte is ever dropped, so every accepted byte moves the parser by exactly one step. The bench keeps to this by driving one byte per valid cycle with an idle cycle after each, and it sets `in_byte` to a start code during idle gaps to show that it is ignored. Lengths stay small, so each frame's content and its positions can be predicted arithmetically.

// File: rtl/frx_pkg.sv
package frx_pkg;
  typedef enum logic [2:0] {
    S_WAIT,
    S_IDENT,
    S_LENGTH,
    S_BODY,
    S_SEAL
  } frx_state_e;
endpackage

// File: rtl/frx_shift.sv
module frx_shift #(
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               shift_en,
  input  logic [7:0]         in_byte,
  output logic [8*BYTES-1:0] value,
  output logic [8*BYTES-1:0] next_value
);
  localparam int W = 8 * BYTES;

  assign next_value = {value[W-9:0], in_byte};

  always_ff @(posedge clk) begin
    if (rst || clr) value <= '0;
    else if (shift_en) value <= next_value;
  end
endmodule

// File: rtl/frx_seq.sv
module frx_seq
  import frx_pkg::*;
#(
  parameter int         BYTES      = 4,
  parameter logic [7:0] START_CODE = 8'hA5,
  parameter logic [7:0] STOP_CODE  = 8'h5A,
  parameter logic [7:0] EOT_CODE   = 8'h04
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [7:0]         in_byte,
  input  logic [8*BYTES-1:0] len_q,
  input  logic [8*BYTES-1:0] len_next,
  output logic               clr_fields,
  output logic               id_shift,
  output logic               len_shift,
  output logic               hdr_valid,
  output logic               pay_valid,
  output logic [7:0]         pay_byte,
  output logic [8*BYTES-1:0] pay_index,
  output logic               frame_done,
  output logic               frame_err,
  output logic               close_req
);
  localparam int W     = 8 * BYTES;
  localparam int CNT_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BYTES - 1);

  frx_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     idx;

  assign clr_fields = in_valid && (state == S_WAIT) && (in_byte == START_CODE);
  assign id_shift   = in_valid && (state == S_IDENT);
  assign len_shift  = in_valid && (state == S_LENGTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_WAIT;
      cnt        <= '0;
      idx        <= '0;
      hdr_valid  <= 1'b0;
      pay_valid  <= 1'b0;
      pay_byte   <= '0;
      pay_index  <= '0;
      frame_done <= 1'b0;
      frame_err  <= 1'b0;
      close_req  <= 1'b0;
    end else begin
      hdr_valid  <= 1'b0;
      pay_valid  <= 1'b0;
      frame_done <= 1'b0;
      frame_err  <= 1'b0;
      close_req  <= 1'b0;
      if (in_valid) begin
        case (state)
          S_WAIT: begin
            if (in_byte == START_CODE) begin
              state <= S_IDENT;
              cnt   <= '0;
            end else if (in_byte == EOT_CODE) begin
              close_req <= 1'b1;
            end
          end
          S_IDENT: begin
            if (cnt == LAST_CNT) begin
              state <= S_LENGTH;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_LENGTH: begin
            if (cnt == LAST_CNT) begin
              cnt       <= '0;
              idx       <= '0;
              hdr_valid <= 1'b1;
              state     <= (len_next == '0) ? S_SEAL : S_BODY;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_BODY: begin
            pay_valid <= 1'b1;
            pay_byte  <= in_byte;
            pay_index <= idx;
            idx       <= idx + 1'b1;
            if (idx == len_q - 1'b1) state <= S_SEAL;
          end
          S_SEAL: begin
            if (in_byte == STOP_CODE) frame_done <= 1'b1;
            else                      frame_err  <= 1'b1;
            state <= S_WAIT;
          end
          default: state <= S_WAIT;
        endcase
      end
    end
  end

  // R11
  one_event_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hdr_valid, pay_valid, frame_done, frame_err, close_req}));

  // R11
  strobe_needs_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid || pay_valid || frame_done || frame_err || close_req) |-> $past(in_valid));

  // R6
  index_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    pay_valid |-> (pay_index < len_q));

  // R3
  close_between_frames_chk: assert property (@(posedge clk) disable iff (rst)
    close_req |-> $past(state == S_WAIT));

  // R7
  empty_goes_to_seal_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |-> (state == ((len_q == '0) ? S_SEAL : S_BODY)));

  // R8
  seal_returns_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_done || frame_err) |-> (state == S_WAIT));
endmodule

// File: rtl/frame_rx.sv
module frame_rx #(
  parameter int         FIELD_BYTES = 4,
  parameter logic [7:0] START_CODE  = 8'hA5,
  parameter logic [7:0] STOP_CODE   = 8'h5A,
  parameter logic [7:0] EOT_CODE    = 8'h04
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [7:0]                in_byte,
  output logic [8*FIELD_BYTES-1:0]  msg_id,
  output logic [8*FIELD_BYTES-1:0]  msg_len,
  output logic                      hdr_valid,
  output logic                      pay_valid,
  output logic [7:0]                pay_byte,
  output logic [8*FIELD_BYTES-1:0]  pay_index,
  output logic                      frame_done,
  output logic                      frame_err,
  output logic                      close_req
);
  localparam int FW = 8 * FIELD_BYTES;

  logic          clr_fields, id_shift, len_shift;
  logic [FW-1:0] id_next, len_next;

  frx_shift #(.BYTES(FIELD_BYTES)) u_id (
    .clk(clk), .rst(rst), .clr(clr_fields), .shift_en(id_shift),
    .in_byte(in_byte), .value(msg_id), .next_value(id_next)
  );

  frx_shift #(.BYTES(FIELD_BYTES)) u_len (
    .clk(clk), .rst(rst), .clr(clr_fields), .shift_en(len_shift),
    .in_byte(in_byte), .value(msg_len), .next_value(len_next)
  );

  frx_seq #(
    .BYTES(FIELD_BYTES), .START_CODE(START_CODE),
    .STOP_CODE(STOP_CODE), .EOT_CODE(EOT_CODE)
  ) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .len_q(msg_len), .len_next(len_next),
    .clr_fields(clr_fields), .id_shift(id_shift), .len_shift(len_shift),
    .hdr_valid(hdr_valid), .pay_valid(pay_valid), .pay_byte(pay_byte),
    .pay_index(pay_index), .frame_done(frame_done), .frame_err(frame_err),
    .close_req(close_req)
  );

  logic unused_id_next;
  assign unused_id_next = ^id_next;
endmodule

// File: tb/tb_frame_rx.sv
module tb_frame_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic [31:0] msg_id, msg_len, pay_index;
  logic        hdr_valid, pay_valid, frame_done, frame_err, close_req;
  logic [7:0]  pay_byte;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  frame_rx dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .msg_id(msg_id), .msg_len(msg_len), .hdr_valid(hdr_valid),
    .pay_valid(pay_valid), .pay_byte(pay_byte), .pay_index(pay_index),
    .frame_done(frame_done), .frame_err(frame_err), .close_req(close_req)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit quiet();
    return !(hdr_valid || pay_valid || frame_done || frame_err || close_req);
  endfunction

  function automatic logic [7:0] gen(input logic [31:0] id, input int i);
    if (i == 0) return 8'h04;
    if (i == 1) return 8'hA5;
    if (i == 2) return 8'h5A;
    return 8'(id[7:0] * 8'd29 + 8'(i) * 8'd13);
  endfunction

  // One byte per valid cycle followed by an idle cycle; start code on the bus while idle.
  task automatic push(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
    in_byte  = 8'hA5;
  endtask

  task automatic send_frame(input logic [31:0] id, input logic [31:0] len, input bit bad);
    push(8'hA5);
    check(quiet(), "R4 start byte raises no strobe", 32'(hdr_valid), 0);
    for (int k = 0; k < 4; k++) begin
      push(id[31-8*k -: 8]);
      check(quiet(), "R10 identifier byte raises no strobe", 32'(close_req), 0);
    end
    for (int k = 0; k < 4; k++) begin
      push(len[31-8*k -: 8]);
      if (k < 3) check(quiet(), "R5 early length byte raises no strobe", 32'(hdr_valid), 0);
    end
    check(hdr_valid, "R5 header strobe", 32'(hdr_valid), 1);
    check(msg_id == id, "R4 identifier big-endian", msg_id, id);
    check(msg_len == len, "R5 length big-endian", msg_len, len);
    for (int i = 0; i < int'(len); i++) begin
      logic [7:0] b;
      b = gen(id, i);
      push(b);
      check(pay_valid && pay_byte == b, "R6 content byte", {23'd0, pay_valid, pay_byte}, {24'd1, b});
      check(pay_index == 32'(i), "R6 content index", pay_index, 32'(i));
      if (i < 3) check(!close_req && !frame_done, "R10 code as content", {close_req, frame_done}, 0);
    end
    push(bad ? 8'h5B : 8'h5A);
    if (bad) check(frame_err && !frame_done, "R9 bad stop byte", {frame_err, frame_done}, 32'd2);
    else if (len == 0) check(frame_done && !frame_err, "R7 empty frame sealed", {frame_done, frame_err}, 32'd2);
    else check(frame_done && !frame_err, "R8 good stop byte", {frame_done, frame_err}, 32'd2);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] ids [5];
    ids = '{32'h0000_0000, 32'h0000_0001, 32'h0000_0002, 32'h0000_000C, 32'hDEAD_BEEF};

    repeat (4) @(negedge clk);
    check(quiet() && msg_id == 0 && msg_len == 0, "R1 reset state", msg_id | msg_len, 0);
    rst = 1'b0;
    @(negedge clk);
    check(quiet() && msg_id == 0 && msg_len == 0, "R1 first cycle after reset", msg_id | msg_len, 0);

    // R11: start code on bus with in_valid low must not open a frame
    in_byte = 8'hA5;
    repeat (6) begin
      @(negedge clk);
      check(quiet(), "R11 invalid cycle ignored", 32'(hdr_valid), 0);
    end
    push(8'h04);
    check(close_req, "R11 still between frames after invalid start codes", 32'(close_req), 1);
    send_frame(32'h0102_0304, 32'd2, 1'b0);

    // R2: sweep every other value between frames
    for (int v = 0; v < 256; v++) begin
      if (v != 8'hA5 && v != 8'h04) begin
        push(8'(v));
        check(quiet(), "R2 idle byte ignored", 32'(v), 0);
      end
    end
    send_frame(32'h0000_000C, 32'd4, 1'b0);

    // R3: close request pulse
    push(8'h04);
    check(close_req, "R3 close request", 32'(close_req), 1);
    @(negedge clk);
    check(!close_req, "R3 close request is one cycle", 32'(close_req), 0);

    // Sweep of lengths and identifiers
    for (int len = 0; len <= 6; len++)
      for (int j = 0; j < 5; j++)
        send_frame(ids[j], 32'(len), 1'b0);

    // R9: bad stop with and without content, then recovery
    send_frame(32'h0000_0002, 32'd5, 1'b1);
    send_frame(32'h0000_000C, 32'd3, 1'b0);
    send_frame(32'h0000_0000, 32'd0, 1'b1);
    push(8'h04);
    check(close_req, "R9 back between frames after error", 32'(close_req), 1);

    // Longer content crossing the low byte of the index
    send_frame(32'h0000_000C, 32'd300, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule